// File: doc/BRIEF.md
# Boundary-Scan Register with Test Modes

This block is the boundary register that sits between a device's core logic and its pads. It holds one observe-only cell for each input pad. Each output pad has two cells: one for the data level and one for the driver enable. A test access controller outside the block supplies three strobes, for capture, shift and update, and a two-bit decoded instruction. The block uses these to sample pad and core values in parallel, move them serially from `tdi` to `tdo`, and copy shifted data into update latches on the falling test-clock edge.

In external-test mode the update latches own the output pads and their enables. In sample/preload mode the same chain can be read and loaded while the pads stay under core control. Data preloaded this way is driven at once when external-test mode is selected. In bypass mode a single flop replaces the chain between `tdi` and `tdo`, and the chain and latches keep their contents. An active-low asynchronous reset clears all test state and returns the pads to functional control.

Top module: `scan_boundary_reg`

## Requirements
- R1: The chain is L = N_IN + 2*N_OUT stages long, with stage 0 next to `tdo`. Stages 0..N_IN-1 capture `pin_in[i]`. Stage N_IN+k captures `core_out[k]`. Stage N_IN+N_OUT+k captures `core_oe[k]`. Capture happens on a rising `tck` edge with `capture_en` high while `mode_sel` is 0 or 1.
- R2: On a rising edge with `shift_en` high and `mode_sel` 0 or 1, every stage takes the value of its neighbour one place nearer `tdi`, and stage L-1 takes `tdi`.
- R3: On every falling `tck` edge, `tdo` loads stage 0 when `mode_sel` is 0 or 1, or the bypass flop otherwise. It holds that value until the next falling edge.
- R4: On a falling edge with `update_en` high and `mode_sel` 0 or 1, the data latches copy stages N_IN..N_IN+N_OUT-1 and the enable latches copy the stages above them. At all other times the latches hold their values.
- R5: With `mode_sel` = 0 (external test), `pad_out[k]` is data latch k and `pad_oe[k]` is enable latch k.
- R6: With `mode_sel` 1, 2 or 3, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`. In every mode `core_in` equals `pin_in`.
- R7: Latch contents loaded under `mode_sel` = 1 reach the pads as soon as `mode_sel` becomes 0, with no further strobe.
- R8: With `mode_sel` = 2 or 3 (bypass), a one-bit path links `tdi` to `tdo`: capture loads 0 and shift loads `tdi`. Chain stages and update latches do not change under any strobe.
- R9: While `trst_n` is low, all stages, latches, the bypass flop and `tdo` are 0, and the pads follow the core in every mode.
- R10: When `capture_en` and `shift_en` are both high at the same rising edge, capture takes effect and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| mode_sel | input | 2 | Decoded instruction: 0 external test, 1 sample/preload, 2 or 3 bypass |
| capture_en | input | 1 | Capture strobe from the data-register capture state |
| shift_en | input | 1 | Shift strobe from the data-register shift state |
| update_en | input | 1 | Update strobe from the data-register update state |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling edge |
| pin_in | input | N_IN | Levels from the input pads |
| core_in | output | N_IN | Input pad levels passed to the core |
| core_out | input | N_OUT | Core output data |
| core_oe | input | N_OUT | Core output enables |
| pad_out | output | N_OUT | Data driven to the output pads |
| pad_oe | output | N_OUT | Driver enables to the output pads |

## Verification
Two events can collide in one rising edge: the capture and shift strobes. The bench raises both together for a single cycle in external-test mode. It then reads the whole chain out and requires the full captured image with no shifted bit in it. A second collision happens at the mode boundary. After a bypass session (capture, shift and update all issued) the bench switches back and reads the chain and pads, which must show the older preload and not the bypass traffic.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    MODE_EXT    = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_BYP_A  = 2'b10,
    MODE_BYP_B  = 2'b11
  } bscan_mode_e;

  function automatic int unsigned chain_len(input int unsigned n_in, input int unsigned n_out);
    return n_in + 2 * n_out;
  endfunction

  // Chain is in the scan path for external test and sample/preload.
  function automatic logic chain_path(input logic [1:0] m);
    bscan_mode_e e;
    e = bscan_mode_e'(m);
    return (e == MODE_EXT) || (e == MODE_SAMPLE);
  endfunction

  function automatic logic ext_mode(input logic [1:0] m);
    return bscan_mode_e'(m) == MODE_EXT;
  endfunction

endpackage

// File: rtl/bsr_in_cell.sv
module bsr_in_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_fire,
  input  logic shf_fire,
  input  logic cap_d,
  input  logic ser_in,
  output logic stage_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       stage_q <= 1'b0;
    else if (cap_fire) stage_q <= cap_d;
    else if (shf_fire) stage_q <= ser_in;
  end
endmodule

// File: rtl/bsr_out_cell.sv
module bsr_out_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_fire,
  input  logic shf_fire,
  input  logic upd_fire,
  input  logic cap_d,
  input  logic ser_in,
  output logic stage_q,
  output logic upd_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       stage_q <= 1'b0;
    else if (cap_fire) stage_q <= cap_d;
    else if (shf_fire) stage_q <= ser_in;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)       upd_q <= 1'b0;
    else if (upd_fire) upd_q <= stage_q;
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 3,
  localparam int unsigned L    = bscan_pkg::chain_len(N_IN, N_OUT)
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             cap_fire,
  input  logic             shf_fire,
  input  logic             upd_fire,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [L-1:0]     stage_vec,
  output logic [N_OUT-1:0] lat_data,
  output logic [N_OUT-1:0] lat_en
);
  localparam int unsigned DATA_BASE = N_IN;
  localparam int unsigned EN_BASE   = N_IN + N_OUT;

  logic [L-1:0] ser_in;

  for (genvar i = 0; i < L; i++) begin : g_link
    if (i == L - 1) begin : g_head
      assign ser_in[i] = tdi;
    end else begin : g_mid
      assign ser_in[i] = stage_vec[i+1];
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    bsr_in_cell u_cell (
      .tck      (tck),
      .trst_n   (trst_n),
      .cap_fire (cap_fire),
      .shf_fire (shf_fire),
      .cap_d    (pin_in[i]),
      .ser_in   (ser_in[i]),
      .stage_q  (stage_vec[i])
    );
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    bsr_out_cell u_data (
      .tck      (tck),
      .trst_n   (trst_n),
      .cap_fire (cap_fire),
      .shf_fire (shf_fire),
      .upd_fire (upd_fire),
      .cap_d    (core_out[k]),
      .ser_in   (ser_in[DATA_BASE+k]),
      .stage_q  (stage_vec[DATA_BASE+k]),
      .upd_q    (lat_data[k])
    );
    bsr_out_cell u_en (
      .tck      (tck),
      .trst_n   (trst_n),
      .cap_fire (cap_fire),
      .shf_fire (shf_fire),
      .upd_fire (upd_fire),
      .cap_d    (core_oe[k]),
      .ser_in   (ser_in[EN_BASE+k]),
      .stage_q  (stage_vec[EN_BASE+k]),
      .upd_q    (lat_en[k])
    );
  end
endmodule

// File: rtl/bsr_bypass.sv
module bsr_bypass (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_fire,
  input  logic shf_fire,
  input  logic tdi,
  output logic byp_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       byp_q <= 1'b0;
    else if (cap_fire) byp_q <= 1'b0;
    else if (shf_fire) byp_q <= tdi;
  end
endmodule

// File: rtl/bsr_padmux.sv
module bsr_padmux #(
  parameter int unsigned N_OUT = 3
) (
  input  logic             ext_on,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_OUT-1:0] lat_data,
  input  logic [N_OUT-1:0] lat_en,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_pad
    assign pad_out[k] = ext_on ? lat_data[k] : core_out[k];
    assign pad_oe[k]  = ext_on ? lat_en[k]   : core_oe[k];
  end
endmodule

// File: rtl/scan_boundary_reg.sv
module scan_boundary_reg #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [1:0]       mode_sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int unsigned L = bscan_pkg::chain_len(N_IN, N_OUT);

  // Named internal events, visible to the bound checker.
  logic             chain_sel;
  logic             ext_on;
  logic             cap_fire;
  logic             shf_fire;
  logic             upd_fire;
  logic             byp_cap;
  logic             byp_shf;
  logic             ser_sel;
  logic [L-1:0]     stage_vec;
  logic [N_OUT-1:0] lat_data;
  logic [N_OUT-1:0] lat_en;
  logic             byp_q;

  assign chain_sel = bscan_pkg::chain_path(mode_sel);
  assign ext_on    = bscan_pkg::ext_mode(mode_sel) & trst_n;
  assign cap_fire  = capture_en & chain_sel;
  assign shf_fire  = shift_en & chain_sel;
  assign upd_fire  = update_en & chain_sel;
  assign byp_cap   = capture_en & ~chain_sel;
  assign byp_shf   = shift_en & ~chain_sel;

  bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
    .tck       (tck),
    .trst_n    (trst_n),
    .cap_fire  (cap_fire),
    .shf_fire  (shf_fire),
    .upd_fire  (upd_fire),
    .tdi       (tdi),
    .pin_in    (pin_in),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .stage_vec (stage_vec),
    .lat_data  (lat_data),
    .lat_en    (lat_en)
  );

  bsr_bypass u_bypass (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_fire (byp_cap),
    .shf_fire (byp_shf),
    .tdi      (tdi),
    .byp_q    (byp_q)
  );

  bsr_padmux #(.N_OUT(N_OUT)) u_pads (
    .ext_on   (ext_on),
    .core_out (core_out),
    .core_oe  (core_oe),
    .lat_data (lat_data),
    .lat_en   (lat_en),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign ser_sel = chain_sel ? stage_vec[0] : byp_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= ser_sel;
  end

  assign core_in = pin_in;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 3,
  localparam int unsigned L    = N_IN + 2 * N_OUT
) (
  input logic             tck,
  input logic             trst_n,
  input logic [1:0]       mode_sel,
  input logic             capture_en,
  input logic             shift_en,
  input logic             tdi,
  input logic             tdo,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] core_oe,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe,
  input logic             cap_fire,
  input logic             shf_fire,
  input logic             upd_fire,
  input logic [L-1:0]     stage_vec,
  input logic [N_OUT-1:0] lat_data,
  input logic [N_OUT-1:0] lat_en
);
  p_capture_pin_r1: assert property (@(posedge tck) disable iff (!trst_n)
    cap_fire |=> stage_vec[N_IN-1:0] == $past(pin_in))
    else $error("capture of input pads wrong");

  p_shift_entry_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (shf_fire && !cap_fire) |=> stage_vec[L-1] == $past(tdi))
    else $error("tdi did not enter the chain head");

  p_tdo_from_chain_r3: assert property (@(negedge tck) disable iff (!trst_n)
    (mode_sel[1] == 1'b0) |=> tdo == $past(stage_vec[0]))
    else $error("tdo does not follow stage 0");

  p_update_copy_r4: assert property (@(negedge tck) disable iff (!trst_n)
    upd_fire |=> {lat_en, lat_data} == $past(stage_vec[L-1:N_IN]))
    else $error("update latches did not copy the chain");

  p_ext_pads_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel == 2'b00) |-> (pad_out == lat_data) && (pad_oe == lat_en))
    else $error("external test pads do not follow latches");

  p_functional_pads_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel != 2'b00) |-> (pad_out == core_out) && (pad_oe == core_oe))
    else $error("functional pads disturbed");

  p_bypass_frozen_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel[1] && (capture_en || shift_en)) |=> $stable(stage_vec))
    else $error("chain moved in bypass");

  p_capture_wins_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_fire && shf_fire) |=> stage_vec[L-1] == $past(core_oe[N_OUT-1]))
    else $error("shift overrode capture");

  always @(negedge tck) begin
    if (!trst_n) begin
      p_reset_clear_r9: assert ({lat_en, lat_data, stage_vec, tdo} == '0)
        else $error("state not cleared in reset");
    end
  end
endmodule

bind scan_boundary_reg bsr_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr_checker (
  .tck        (tck),
  .trst_n     (trst_n),
  .mode_sel   (mode_sel),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .tdi        (tdi),
  .tdo        (tdo),
  .pin_in     (pin_in),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .cap_fire   (cap_fire),
  .shf_fire   (shf_fire),
  .upd_fire   (upd_fire),
  .stage_vec  (stage_vec),
  .lat_data   (lat_data),
  .lat_en     (lat_en)
);

// File: tb/tb_scan_boundary_reg.sv
module tb_scan_boundary_reg;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + 2 * NO;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic [1:0]    mode_sel = 2'd1;
  logic          capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic          tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  logic [L-1:0]    m_stage;
  logic [2*NO-1:0] m_lat;

  scan_boundary_reg #(.N_IN(NI), .N_OUT(NO)) dut (
    .tck(tck), .trst_n(trst_n), .mode_sel(mode_sel),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #10 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  // Advance to 2 ns after the next rising edge, passing one falling edge.
  task automatic step();
    @(posedge tck);
    #2;
  endtask

  function automatic logic [L-1:0] image(input logic [NI-1:0] p, input logic [NO-1:0] d,
                                         input logic [NO-1:0] e);
    logic [L-1:0] v;
    for (int i = 0; i < NI; i++) v[i] = p[i];
    for (int k = 0; k < NO; k++) begin
      v[NI+k]    = d[k];
      v[NI+NO+k] = e[k];
    end
    return v;
  endfunction

  function automatic logic [L-1:0] bypass_stream(input logic [L-1:0] din);
    return {din[L-2:0], 1'b0};
  endfunction

  function automatic logic is_chain(input logic [1:0] m);
    return m < 2'd2;
  endfunction

  task automatic do_capture();
    capture_en = 1'b1; step(); capture_en = 1'b0;
    if (is_chain(mode_sel)) m_stage = image(pin_in, core_out, core_oe);
  endtask

  task automatic do_update();
    update_en = 1'b1; step(); update_en = 1'b0;
    if (is_chain(mode_sel)) m_lat = m_stage[L-1:NI];
  endtask

  task automatic do_shift(input logic [L-1:0] din, output logic [L-1:0] dout);
    shift_en = 1'b1;
    for (int k = 0; k < L; k++) begin
      tdi = din[k];
      step();
      dout[k] = tdo;
    end
    shift_en = 1'b0;
    if (is_chain(mode_sel)) m_stage = din;
  endtask

  task automatic check_pads(input string req);
    if (mode_sel == 2'd0) begin
      chk(req, pad_out, m_lat[NO-1:0]);
      chk(req, pad_oe, m_lat[2*NO-1:NO]);
    end else begin
      chk(req, pad_out, core_out);
      chk(req, pad_oe, core_oe);
    end
    chk("R6 core_in", core_in, pin_in);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [L-1:0] dout, pat, exp_v;
    void'($urandom(32'h5EED_B5C4));
    m_stage = '0;
    m_lat = '0;
    core_out = 3'b101; core_oe = 3'b011; pin_in = 4'b1001; mode_sel = 2'd0;
    #5;
    // R9: reset state, pads functional even in external-test mode
    chk("R9 tdo reset", tdo, 1'b0);
    chk("R9 pad_out in reset", pad_out, core_out);
    chk("R9 pad_oe in reset", pad_oe, core_oe);
    @(posedge tck); #2;
    trst_n = 1'b1;
    mode_sel = 2'd1;

    // R1 R3: sample capture, read out in chain order; R2 shifted pattern
    pin_in = 4'b0110; core_out = 3'b100; core_oe = 3'b001;
    do_capture();
    exp_v = image(pin_in, core_out, core_oe);
    pat = 10'b1100101101;
    do_shift(pat, dout);
    chk("R1 R3 captured image", dout, exp_v);
    do_update();
    check_pads("R6 sample keeps pads functional");

    // R7: preload reaches pads on mode switch without strobe
    mode_sel = 2'd0;
    #1;
    check_pads("R7 preload driven");
    #1;

    // R2: shifted pattern read back after a second pass
    do_shift(10'b0011001010, dout);
    chk("R2 shifted data", dout, pat);

    // R10: capture and shift together
    pin_in = 4'b1010; core_out = 3'b011; core_oe = 3'b110;
    capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    step();
    capture_en = 1'b0; shift_en = 1'b0;
    exp_v = image(pin_in, core_out, core_oe);
    do_shift(10'b0101010101, dout);
    chk("R10 capture wins", dout, exp_v);
    do_update();
    check_pads("R4 R5 external pads");

    // R8: bypass leaves chain and latches untouched
    mode_sel = 2'd1;
    pat = 10'b1011100010;
    do_shift(pat, dout);
    do_update();
    for (int b = 2; b < 4; b++) begin
      mode_sel = 2'(b);
      do_capture();
      do_shift(10'b0110011011, dout);
      chk("R8 one-bit path", dout, bypass_stream(10'b0110011011));
      do_update();
      check_pads("R8 bypass pads functional");
    end
    mode_sel = 2'd0;
    #1;
    check_pads("R8 latches kept");
    #1;
    do_shift(10'b0, dout);
    chk("R8 chain kept", dout, pat);

    // Random mix of modes
    for (int it = 0; it < 40; it++) begin
      mode_sel = 2'($urandom_range(0, 3));
      pin_in = NI'($urandom); core_out = NO'($urandom); core_oe = NO'($urandom);
      pat = L'($urandom);
      if (is_chain(mode_sel)) exp_v = image(pin_in, core_out, core_oe);
      else exp_v = bypass_stream(pat);
      do_capture();
      do_shift(pat, dout);
      chk(is_chain(mode_sel) ? "R1 R2 random capture" : "R8 random bypass", dout, exp_v);
      do_update();
      check_pads("R4 R5 R6 random pads");
    end

    // R9: asynchronous reset mid-run
    mode_sel = 2'd0;
    do_shift(10'b1111111111, dout);
    do_update();
    check_pads("R5 before reset");
    trst_n = 1'b0;
    #1;
    chk("R9 pads functional in reset", pad_out, core_out);
    chk("R9 tdo cleared", tdo, 1'b0);
    step();
    trst_n = 1'b1;
    m_lat = '0;
    m_stage = '0;
    #1;
    check_pads("R9 latches cleared");
    #1;
    do_shift(10'b0, dout);
    chk("R9 chain cleared", dout, 10'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule